// File: doc/BRIEF.md
# Split-Segment Approximate Adder

This block adds two unsigned operands and accepts a small, bounded error in the low-order bits in return for a short carry path. The operands are cut into an upper accurate segment and a lower inaccurate segment. The upper segment is a plain ripple-carry adder whose carry-in is held at zero. Its carry-out becomes the top bit of a result one bit wider than the operands. The lower segment carries nothing, either inside itself or into the upper segment.

Each lower sum bit is the exclusive-OR of its two operand bits. A control scan starts at the top of the lower segment and moves downward. It finds the highest position where both operand bits are 1. That position and every position below it are forced to 1. The total width and the lower-segment width are parameters, and the two segments need not be the same size. A lower width of zero gives an exact adder. The sum is held in an output register, so it appears one clock after the operands are presented.

Top module: `split_approx_adder`

## Requirements
- R1: Result bits WIDTH down to LOW_W equal the exact sum of the upper LOW_W..WIDTH-1 operand slices, with no carry-in.
- R2: A lower result bit is the XOR of its two operand bits when no lower position at or above it has both operand bits set to 1.
- R3: At the highest lower position where both operand bits are 1, that result bit and all lower result bits are 1.
- R4: A carry produced in the lower segment never changes the upper result bits. For example, 0x0080 + 0x0080 gives 0x00FF in the 16/8 split.
- R5: With LOW_W = 0 the result equals the exact sum of the operands.
- R6: With WIDTH = 16 and LOW_W = 8, 45978 + 26899 gives 72863.
- R7: The result is registered: it reflects the operands sampled at the previous rising clock edge. While rst_n is low it reads 0.
- R8: The carry-out of the upper segment appears as result bit WIDTH. For example, 0xFF00 + 0x0100 gives 0x10000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset; clears the result |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH+1 | Registered approximate sum |

## Verification
Every sum is due exactly one rising edge after its operands are applied, because the only register in the path is the output stage. The bench changes the operands on a falling edge. It compares the result on the next falling edge, after exactly one rising edge, against a bench model of the split rule. A second instance with no lower segment is compared against the exact sum at the same point. The checker relates each registered result to the operands sampled one edge earlier. It does not start until one edge has passed after reset is released.

// File: rtl/eta_pkg.sv
package eta_pkg;
    typedef enum logic {
        CELL_XOR   = 1'b0,
        CELL_FORCE = 1'b1
    } cell_mode_e;
endpackage

// File: rtl/eta_ripple.sv
module eta_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   s
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i]       = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign s[W] = carry[W];
endmodule

// File: rtl/eta_force_scan.sv
module eta_force_scan #(
    parameter int W = 8
) (
    input  logic [W-1:0]                a,
    input  logic [W-1:0]                b,
    output eta_pkg::cell_mode_e [W-1:0] mode
);
    logic [W-1:0] both;
    logic [W-1:0] seen;

    assign both = a & b;
    assign seen[W-1] = both[W-1];

    for (genvar i = W - 2; i >= 0; i--) begin : g_scan
        assign seen[i] = seen[i+1] | both[i];
    end

    for (genvar i = 0; i < W; i++) begin : g_mode
        assign mode[i] = seen[i] ? eta_pkg::CELL_FORCE : eta_pkg::CELL_XOR;
    end
endmodule

// File: rtl/eta_carry_free.sv
module eta_carry_free #(
    parameter int W = 8
) (
    input  logic [W-1:0]                a,
    input  logic [W-1:0]                b,
    input  eta_pkg::cell_mode_e [W-1:0] mode,
    output logic [W-1:0]                s
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign s[i] = (mode[i] == eta_pkg::CELL_FORCE) ? 1'b1 : (a[i] ^ b[i]);
    end
endmodule

// File: rtl/split_approx_adder.sv
module split_approx_adder #(
    parameter int WIDTH = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum
);
    localparam int HIGH_W = WIDTH - LOW_W;

    typedef struct packed {
        logic [WIDTH:0] sum;
    } state_t;

    state_t state_d, state_q;
    logic [WIDTH:0]  raw_sum;
    logic [HIGH_W:0] high_sum;

    eta_ripple #(.W(HIGH_W)) u_high (
        .a (op_a[WIDTH-1:LOW_W]),
        .b (op_b[WIDTH-1:LOW_W]),
        .s (high_sum)
    );

    if (LOW_W > 0) begin : g_low
        eta_pkg::cell_mode_e [LOW_W-1:0] low_mode;
        logic [LOW_W-1:0]                low_sum;

        eta_force_scan #(.W(LOW_W)) u_scan (
            .a    (op_a[LOW_W-1:0]),
            .b    (op_b[LOW_W-1:0]),
            .mode (low_mode)
        );

        eta_carry_free #(.W(LOW_W)) u_free (
            .a    (op_a[LOW_W-1:0]),
            .b    (op_b[LOW_W-1:0]),
            .mode (low_mode),
            .s    (low_sum)
        );

        assign raw_sum = {high_sum, low_sum};
    end else begin : g_exact
        assign raw_sum = high_sum;
    end

    always_comb begin
        state_d     = state_q;
        state_d.sum = raw_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum = state_q.sum;
endmodule

// File: rtl/split_approx_adder_chk.sv
module split_approx_adder_chk #(
    parameter int WIDTH = 16,
    parameter int LOW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH:0]   sum
);
    localparam int HIGH_W = WIDTH - LOW_W;

    logic [HIGH_W:0] hi_expect;
    logic [WIDTH:0]  full_exact;

    assign hi_expect  = {1'b0, op_a[WIDTH-1:LOW_W]} + {1'b0, op_b[WIDTH-1:LOW_W]};
    assign full_exact = {1'b0, op_a} + {1'b0, op_b};

    // R1 R4 R8
    hi_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sum[WIDTH:LOW_W] == $past(hi_expect));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> sum == '0);

    // R3
    no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sum <= $past(full_exact));

    if (LOW_W > 0) begin : g_low_chk
        logic any_both;
        assign any_both = |(op_a[LOW_W-1:0] & op_b[LOW_W-1:0]);

        // R2
        low_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(any_both)) |->
                sum[LOW_W-1:0] == $past(op_a[LOW_W-1:0] ^ op_b[LOW_W-1:0]));

        // R3
        low_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(any_both)) |-> sum[0] == 1'b1);
    end else begin : g_exact_chk
        // R5
        exact_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> sum == $past(full_exact));
    end
endmodule

bind split_approx_adder split_approx_adder_chk #(
    .WIDTH (WIDTH),
    .LOW_W (LOW_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_a  (op_a),
    .op_b  (op_b),
    .sum   (sum)
);

// File: tb/split_approx_adder_bench.sv
`timescale 1ns/1ps
module split_approx_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [16:0] sum;
    logic [7:0]  ex_a = '0;
    logic [7:0]  ex_b = '0;
    logic [8:0]  ex_sum;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    split_approx_adder #(.WIDTH(16), .LOW_W(8)) u_split_approx_adder (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b), .sum (sum)
    );

    split_approx_adder #(.WIDTH(8), .LOW_W(0)) u_split_approx_adder_exact (
        .clk (clk), .rst_n (rst_n), .op_a (ex_a), .op_b (ex_b), .sum (ex_sum)
    );

    function automatic logic [32:0] ref_sum(input logic [31:0] a, input logic [31:0] b,
                                            input int l);
        logic [32:0] hi;
        logic [32:0] lo;
        bit          forced;
        hi = {1'b0, a >> l} + {1'b0, b >> l};
        lo = '0;
        forced = 1'b0;
        for (int i = l - 1; i >= 0; i--) begin
            if (forced || (a[i] && b[i])) begin
                forced = 1'b1;
                lo[i] = 1'b1;
            end else begin
                lo[i] = a[i] ^ b[i];
            end
        end
        return (hi << l) | lo;
    endfunction

    task automatic check(input string tag, input logic [32:0] got, input logic [32:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        ex_a = a[7:0];
        ex_b = b[7:0];
        @(negedge clk);
        check(tag, {16'b0, sum}, ref_sum({16'b0, a}, {16'b0, b}, 8));
        check("R5 exact", {24'b0, ex_sum}, ref_sum({24'b0, a[7:0]}, {24'b0, b[7:0]}, 0));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        op_a = 16'hFFFF;
        op_b = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R7 reset", {16'b0, sum}, 33'd0);
        check("R7 reset exact", {24'b0, ex_sum}, 33'd0);
        rst_n = 1'b1;

        apply("R6 example", 16'd45978, 16'd26899);
        check("R6 value", {16'b0, sum}, 33'd72863);
        apply("R1 zeros", 16'h0000, 16'h0000);
        apply("R3 all ones", 16'hFFFF, 16'hFFFF);
        check("R3 value", {16'b0, sum}, 33'h1FEFF);
        apply("R4 low carry", 16'h0080, 16'h0080);
        check("R4 value", {16'b0, sum}, 33'h000FF);
        apply("R8 carry out", 16'hFF00, 16'h0100);
        check("R8 value", {16'b0, sum}, 33'h10000);
        apply("R2 xor only", 16'h1255, 16'h34AA);
        check("R2 value", {16'b0, sum}, 33'h046FF);
        apply("R3 bit0 force", 16'h000F, 16'h0001);
        check("R3 bit0 value", {16'b0, sum}, 33'h0000F);
        apply("R1 high only", 16'h7F00, 16'h0100);
        check("R7 latency", {16'b0, sum}, 33'h08000);

        for (int n = 0; n < 300; n++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (n % 4 == 0) rb[7:0] = ~ra[7:0];
            apply("R1 R2 R3 random", ra, rb);
        end

        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reset again", {16'b0, sum}, 33'd0);

        done = 1'b1;
        summary();
    end
endmodule